// File: doc/BRIEF.md
# Acquisition Run-Time Limiter

This block sets how long a data-acquisition run lasts. It keeps three statistics counters. Real time and live time count in coarse ticks, and each tick is `2**TICK_LOG2` sample clocks (65536 by default). The third counter holds accepted events. A start strobe clears all counters and their prescalers and begins a run. The run ends on a stop strobe, or when the counter chosen by the limit mode reaches a 32-bit limit. That limit is built from two 16-bit halves as `lim_lo_i + 65536*lim_hi_i`.

Live time advances only on clocks where the dead-time input is low. Real time advances on every counting clock. Accepted events count one per cycle that the event input is high. A global suspend freezes all counting and the limit check. A hold option decides what happens after a run ends: the counters either keep running or freeze together with the run.

The controller is a three-state machine:
- **IDLE**: after reset, nothing counts.
- **RUN**: acquisition is active.
- **ENDED**: the run is over. The counters keep running here only when hold is off.

It has four transitions:
- **START**: any state to RUN, on `start_i`.
- **LIMIT**: RUN to ENDED, when the selected counter is at or above the limit.
- **STOP**: RUN to ENDED, on `stop_i`.
- **STAY**: all other cases keep the current state.

Top module: `acq_run_limiter`

## Requirements
- R1: After reset, `running_o` and `done_o` are 0 and all three counters read 0. In IDLE, no input other than `start_i` changes any output.
- R2: When `start_i` is high at a clock edge, the next cycle has `running_o`=1, all counters at 0 and both prescalers cleared. This applies from any state, including RUN.
- R3: `real_o` increments once for every `2**TICK_LOG2` counting cycles. A counting cycle is one where the state is RUN, or ENDED with hold off, and `suspend_i`=0 and `start_i`=0.
- R4: `live_o` increments once for every `2**TICK_LOG2` counting cycles that also have `dead_i`=0.
- R5: `events_o` increments by one on each counting cycle with `evt_i`=1.
- R6: With `mode_i`=0, the run never ends on a limit. Only `stop_i` ends it.
- R7: With `mode_i`=1, 2 or 3, the run moves to ENDED on the edge after the live, real or event counter (in that order) is `>=` the limit `lim_lo_i + 65536*lim_hi_i`.
- R8: `done_o` is high for exactly one cycle: the first cycle after a limit ends the run. A stop strobe or a restart never raises it.
- R9: `stop_i` in RUN moves the block to ENDED. When `start_i` and `stop_i` are high together, start wins.
- R10: While `suspend_i`=1, all counters and prescalers hold and the limit check is disabled, so a suspended run never ends on its limit.
- R11: With `hold_i`=0, the counters keep counting in ENDED. With `hold_i`=1, they freeze in ENDED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe; clears counters and begins a run |
| stop_i | input | 1 | Stop strobe |
| suspend_i | input | 1 | Freeze all counting and the limit check |
| mode_i | input | 2 | Limit mode: 0 none, 1 live, 2 real, 3 events |
| hold_i | input | 1 | 1: counters freeze once the run ends |
| lim_lo_i | input | 16 | Low half of the limit |
| lim_hi_i | input | 16 | High half of the limit |
| dead_i | input | 1 | Dead time: live time does not advance |
| evt_i | input | 1 | Accepted-event pulse |
| running_o | output | 1 | Run active (state RUN) |
| done_o | output | 1 | One-cycle pulse when the limit ends the run |
| real_o | output | 32 | Real-time ticks |
| live_o | output | 32 | Live-time ticks |
| events_o | output | 32 | Accepted events |

## Verification
The assertions assume that `mode_i`, `hold_i` and both limit halves are stable while a run is active, since the limit comparison reads them live. They also assume that strobes and levels change only between clock edges. The stimulus follows these assumptions: it changes the mode and the limit only before a start strobe, and drives every input on the falling edge. Dead-time and event inputs are the only ones randomised mid-run, and the design treats both as free-running levels on every cycle.

// File: rtl/acqlim_pkg.sv
package acqlim_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_ENDED = 2'd2
    } run_state_e;

    typedef enum logic [1:0] {
        LIM_NONE   = 2'd0,
        LIM_LIVE   = 2'd1,
        LIM_REAL   = 2'd2,
        LIM_EVENTS = 2'd3
    } lim_mode_e;

    localparam int CH_REAL = 0;
    localparam int CH_LIVE = 1;
    localparam int CH_EVT  = 2;
    localparam int NUM_CH  = 3;

endpackage

// File: rtl/acqlim_channel.sv
module acqlim_channel #(
    parameter int PRE_W = 16,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o
);

    logic tick;
    logic [CNT_W-1:0] count_q;

    generate
        if (PRE_W > 0) begin : g_pre
            logic [PRE_W-1:0] pre_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pre_q <= '0;
                end else if (clr_i) begin
                    pre_q <= '0;
                end else if (inc_i) begin
                    pre_q <= pre_q + 1'b1;
                end
            end
            assign tick = inc_i & (&pre_q);
        end else begin : g_direct
            assign tick = inc_i;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr_i) begin
            count_q <= '0;
        end else if (tick) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count_o = count_q;

    // R3 R4 R5: a counter moves by at most one step per clock unless cleared
    assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (count_o == $past(count_o) || count_o == $past(count_o) + 1'b1));

    // R2: clearing always yields zero
    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> count_o == '0);

endmodule

// File: rtl/acq_run_limiter.sv
module acq_run_limiter
    import acqlim_pkg::*;
#(
    parameter int TICK_LOG2 = 16,
    parameter int HALF_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                stop_i,
    input  logic                suspend_i,
    input  logic [1:0]          mode_i,
    input  logic                hold_i,
    input  logic [HALF_W-1:0]   lim_lo_i,
    input  logic [HALF_W-1:0]   lim_hi_i,
    input  logic                dead_i,
    input  logic                evt_i,
    output logic                running_o,
    output logic                done_o,
    output logic [2*HALF_W-1:0] real_o,
    output logic [2*HALF_W-1:0] live_o,
    output logic [2*HALF_W-1:0] events_o
);

    localparam int CNT_W = 2 * HALF_W;

    run_state_e state_q, state_d;
    lim_mode_e  mode;
    logic       done_q, done_d;
    logic       count_en;
    logic       limit_hit;
    logic [CNT_W-1:0] limit_val;
    logic [CNT_W-1:0] sel_cnt;
    logic [NUM_CH-1:0] ch_inc;
    logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt;

    assign mode      = lim_mode_e'(mode_i);
    assign limit_val = {lim_hi_i, lim_lo_i};

    // counting is allowed in RUN, or in ENDED when hold is off
    always_comb begin
        count_en = 1'b0;
        if (!suspend_i && !start_i) begin
            count_en = (state_q == ST_RUN) ||
                       ((state_q == ST_ENDED) && !hold_i);
        end
    end

    assign ch_inc[CH_REAL] = count_en;
    assign ch_inc[CH_LIVE] = count_en & ~dead_i;
    assign ch_inc[CH_EVT]  = count_en & evt_i;

    generate
        for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
            localparam int PW = (gi == CH_EVT) ? 0 : TICK_LOG2;
            acqlim_channel #(
                .PRE_W (PW),
                .CNT_W (CNT_W)
            ) u_ch (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr_i   (start_i),
                .inc_i   (ch_inc[gi]),
                .count_o (ch_cnt[gi])
            );
        end
    endgenerate

    // choose one counter, then a single comparator
    always_comb begin
        sel_cnt   = '0;
        limit_hit = 1'b0;
        unique case (mode)
            LIM_NONE:   limit_hit = 1'b0;
            LIM_LIVE:   begin sel_cnt = ch_cnt[CH_LIVE]; limit_hit = (sel_cnt >= limit_val); end
            LIM_REAL:   begin sel_cnt = ch_cnt[CH_REAL]; limit_hit = (sel_cnt >= limit_val); end
            LIM_EVENTS: begin sel_cnt = ch_cnt[CH_EVT];  limit_hit = (sel_cnt >= limit_val); end
            default:    limit_hit = 1'b0;
        endcase
    end

    // next state and output decisions
    always_comb begin
        state_d = state_q;
        done_d  = 1'b0;
        if (start_i) begin
            state_d = ST_RUN;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_RUN: begin
                    if (!suspend_i && limit_hit) begin
                        state_d = ST_ENDED;
                        done_d  = 1'b1;
                    end else if (stop_i) begin
                        state_d = ST_ENDED;
                    end
                end
                ST_ENDED: state_d = ST_ENDED;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= done_d;
        end
    end

    assign running_o = (state_q == ST_RUN);
    assign done_o    = done_q;
    assign real_o    = ch_cnt[CH_REAL];
    assign live_o    = ch_cnt[CH_LIVE];
    assign events_o  = ch_cnt[CH_EVT];

    // R8: done appears only as the run drops
    assert_done_on_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!running_o && $past(running_o)));

    // R8: done never lasts two cycles
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: unlimited mode never leaves RUN without a strobe
    assert_unlimited_stays_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && mode_i == 2'd0 && !stop_i) |=> running_o);

    // R10: suspend freezes every counter
    assert_suspend_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (suspend_i && !start_i) |=> ($stable(real_o) && $stable(live_o) && $stable(events_o)));

    // R10: suspended run is not ended by its limit
    assert_suspend_keeps_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && suspend_i && !stop_i) |=> running_o);

    // R11: held counters freeze after the run
    assert_hold_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!running_o && hold_i && !start_i) |=> ($stable(real_o) && $stable(live_o) && $stable(events_o)));

    // R9: a stop strobe ends the run unless start accompanies it
    assert_stop_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && stop_i && !start_i) |=> !running_o);

    // R2: start always leads into RUN
    assert_start_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (running_o && !done_o));

endmodule

// File: tb/sim_acq_run_limiter.sv
module sim_acq_run_limiter;

    localparam int TL  = 3;
    localparam int DIV = 1 << TL;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 0, stop_i = 0, suspend_i = 0, hold_i = 0;
    logic dead_i = 0, evt_i = 0;
    logic [1:0] mode_i = 2'd0;
    logic [15:0] lim_lo_i = 0, lim_hi_i = 0;
    logic running_o, done_o;
    logic [31:0] real_o, live_o, events_o;

    always #5 clk = ~clk;

    acq_run_limiter #(.TICK_LOG2(TL), .HALF_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .suspend_i(suspend_i), .mode_i(mode_i), .hold_i(hold_i),
        .lim_lo_i(lim_lo_i), .lim_hi_i(lim_hi_i), .dead_i(dead_i),
        .evt_i(evt_i), .running_o(running_o), .done_o(done_o),
        .real_o(real_o), .live_o(live_o), .events_o(events_o));

    // behavioural reference
    int          m_st;   // 0 idle, 1 run, 2 ended
    bit          m_done;
    int          m_pr, m_pl;
    int unsigned m_real, m_live, m_ev;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_done = 0; m_pr = 0; m_pl = 0;
            m_real = 0; m_live = 0; m_ev = 0;
        end else begin
            int unsigned lim, cnt;
            bit hit, en;
            lim = {lim_hi_i, lim_lo_i};
            cnt = (mode_i == 1) ? m_live : (mode_i == 2) ? m_real : m_ev;
            hit = (mode_i != 0) && (cnt >= lim);
            en  = !suspend_i && !start_i && (m_st == 1 || (m_st == 2 && !hold_i));
            m_done = 0;
            if (start_i) begin
                m_pr = 0; m_pl = 0; m_real = 0; m_live = 0; m_ev = 0;
            end else if (en) begin
                m_pr++;
                if (m_pr == DIV) begin m_pr = 0; m_real++; end
                if (!dead_i) begin
                    m_pl++;
                    if (m_pl == DIV) begin m_pl = 0; m_live++; end
                end
                if (evt_i) m_ev++;
            end
            if (start_i) m_st = 1;
            else if (m_st == 1 && !suspend_i && hit) begin m_st = 2; m_done = 1; end
            else if (m_st == 1 && stop_i) m_st = 2;
        end
    end

    int vectors = 0, miscompares = 0, cycles = 0;
    bit comparing = 0, finished = 0, rnd = 0;
    string tag = "R1";

    always @(negedge clk) begin
        cycles++;
        if (comparing && !finished) begin
            bit bad;
            bad = 0;
            vectors++;
            if (running_o !== (m_st == 1)) begin bad = 1;
                $display("FAIL %s running: got %0b exp %0b", tag, running_o, (m_st == 1)); end
            if (done_o !== m_done) begin bad = 1;
                $display("FAIL %s done: got %0b exp %0b", tag, done_o, m_done); end
            if (real_o !== m_real) begin bad = 1;
                $display("FAIL %s real: got %0d exp %0d", tag, real_o, m_real); end
            if (live_o !== m_live) begin bad = 1;
                $display("FAIL %s live: got %0d exp %0d", tag, live_o, m_live); end
            if (events_o !== m_ev) begin bad = 1;
                $display("FAIL %s events: got %0d exp %0d", tag, events_o, m_ev); end
            if (bad) miscompares++;
        end
        if (cycles > 190000 && !finished) begin
            finished = 1;
            miscompares++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start_i = 0; stop_i = 0;
            if (rnd) begin
                dead_i = ($urandom % 3) == 0;
                evt_i  = ($urandom % 4) == 0;
            end
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1;
        step(1);
    endtask

    task automatic until_end(input int maxc);
        for (int i = 0; i < maxc; i++) begin
            step(1);
            if (m_st != 1) break;
        end
    endtask

    initial begin
        comparing = 1;
        // R1 reset and idle
        tag = "R1";
        step(3);
        rst_n = 1;
        rnd = 1;
        step(20);
        // R6 R3 R4 R5 unlimited run with random dead time and events
        tag = "R6"; mode_i = 0; lim_lo_i = 0;
        pulse_start(); step(120);
        tag = "R4"; step(60);
        // R2 restart in mid run
        tag = "R2"; pulse_start(); step(30);
        // R9 stop strobe, then start and stop together
        tag = "R9"; @(negedge clk); stop_i = 1; step(10);
        @(negedge clk); start_i = 1; stop_i = 1; step(12);
        @(negedge clk); stop_i = 1; step(5);
        // R7 live-time limit, R8 done pulse, R11 hold on
        tag = "R7"; mode_i = 1; lim_lo_i = 5; hold_i = 1;
        pulse_start(); until_end(400);
        tag = "R8"; step(3);
        tag = "R11"; step(40);
        // R3 real-time limit, R11 counting continues with hold off
        tag = "R3"; mode_i = 2; lim_lo_i = 4; hold_i = 0;
        pulse_start(); until_end(200);
        tag = "R11"; step(50);
        // R7 zero limit ends at once
        tag = "R7"; mode_i = 2; lim_lo_i = 0;
        pulse_start(); step(4);
        // R10 suspend across the limit point
        tag = "R10"; mode_i = 2; lim_lo_i = 2; hold_i = 1;
        pulse_start(); step(10);
        suspend_i = 1; step(40);
        suspend_i = 0; until_end(100); step(5);
        // R5 R7 event limit built from the upper half: 65536 events
        tag = "R5"; rnd = 0; dead_i = 0; evt_i = 1;
        mode_i = 3; lim_lo_i = 0; lim_hi_i = 1;
        pulse_start(); until_end(70000);
        tag = "R7"; step(10);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule